// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator datapath. One operand comes from the accumulator and the other from a temporary operand input. A 4-bit operation code selects one of nine functions: add, subtract, increment, decrement, AND, OR, XOR, compare and rotate-left-circular. The result is combinational. The block also holds a registered five-bit status byte made of sign, zero, auxiliary carry, parity and carry.

Each operation has its own flag rule, and these rules are the reason the block exists. Rotate touches only carry. Increment and decrement leave carry alone. Logical operations force carry and auxiliary carry to fixed values. Compare sets flags exactly as subtract does, but it never requests an accumulator write. The surrounding datapath reads `acc_we_o` to decide whether to commit the result. It raises `flag_en_i` to let the status byte take its new value on the next rising clock edge.

Top module: `acc_alu`

## Requirements
- R1: Operation code 0 is add. `result_o` is (acc+opnd) mod 256, CY (flags bit 0) is the carry out of bit 7, and AC (flags bit 2) is the carry out of bit 3 into bit 4. Example: 7FH+01H gives 80H with flags 5'b10100.
- R2: Code 1 is subtract. The result is (acc-opnd) mod 256. CY=1 when opnd>acc (a borrow). AC=1 when the low nibble of opnd exceeds the low nibble of acc.
- R3: Code 7 is compare. Flags and result are the same as for subtract, and `acc_we_o` is 0.
- R4: Code 2 (increment) gives acc+1, with AC=1 when the low nibble of acc is FH. Code 3 (decrement) gives acc-1, with AC=1 when the low nibble of acc is 0. In both cases CY keeps its old value.
- R5: Code 4 is AND. The result is the bitwise AND, CY is forced to 0 and AC is forced to 1. Example: 7FH AND 0FH gives 0FH with flags 5'b00110.
- R6: Code 5 is OR and code 6 is XOR. Both give the bitwise result and clear CY and AC.
- R7: Code 8 is rotate-left-circular. The result is {acc[6:0],acc[7]} and CY takes acc[7]. S, Z, AC and P keep their old values. Example: 7FH gives FEH with CY=0.
- R8: For every operation except rotate, S (flags bit 4) takes result bit 7, Z (bit 3) is 1 when the result is 00H, and P (bit 1) is 1 when the result has an even number of one bits.
- R9: The flag byte resets to 00000 while `rst_ni` is low. It takes its new value on a rising clock edge only when `flag_en_i` is 1, and otherwise holds.
- R10: Codes 9 to 15 are unused. For these codes `result_o` equals acc, `acc_we_o` is 0, and the flags do not change even when `flag_en_i` is 1.
- R11: `acc_we_o` is 1 for codes 0 to 6 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Temporary (second) operand |
| flag_en_i | input | 1 | Commit new flags at the next rising edge |
| result_o | output | 8 | Combinational result |
| acc_we_o | output | 1 | Result should be written to the accumulator |
| flags_o | output | 5 | Registered flags {S,Z,AC,P,CY} |

## Verification
The assertions assume that the operation code and the operands are stable across each rising edge and hold known values from reset onward. The bench therefore drives every input at the falling edge, starting from defined zeros at time zero. The properties that look back one cycle also rely on `flag_en_i` describing the operation that was present at that same edge. The stimulus always changes the operation code and `flag_en_i` together in a single assignment step. The sweep lowers `flag_en_i` at irregular points, so both the hold rule and the update rules are tested against varied earlier flag states.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_RLC = 4'd8
  } alu_op_e;

  typedef enum logic [1:0] {LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2} logic_sel_e;

  // bit order matters: flags_o[4:0] = {s, z, ac, p, cy}
  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/acc_alu_addsub.sv
`timescale 1ns/1ps
module acc_alu_addsub #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              half_o
);
  logic [DATA_W-1:0] b_eff;
  logic [NIB_W:0]    lo_sum;
  logic [DATA_W:0]   full_sum;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign lo_sum   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                  + {{NIB_W{1'b0}}, sub_i};
  assign full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};

  assign sum_o  = full_sum[DATA_W-1:0];
  // subtract: report borrow, i.e. inverted two's-complement carry
  assign cout_o = full_sum[DATA_W] ^ sub_i;
  assign half_o = lo_sum[NIB_W] ^ sub_i;
endmodule

// File: rtl/acc_alu_logic.sv
`timescale 1ns/1ps
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_sel_e        sel_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_flag_reg.sv
`timescale 1ns/1ps
module acc_alu_flag_reg
  import acc_alu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  flags_t mask_i,
  input  flags_t next_i,
  output flags_t q_o
);
  flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= (q & ~mask_i) | (next_i & mask_i);
  end

  assign q_o = q;
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              flag_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_we_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam int MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W-1:0] as_b, as_sum, lg_y;
  logic              as_sub, as_cout, as_half;
  logic_sel_e        lg_sel;
  logic [DATA_W-1:0] res;
  logic              we, cy_n, ac_n;
  flags_t            mask, nxt, cur;

  assign op = alu_op_e'(op_i);

  acc_alu_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
    .a_i   (acc_i),
    .b_i   (as_b),
    .sub_i (as_sub),
    .sum_o (as_sum),
    .cout_o(as_cout),
    .half_o(as_half)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .sel_i(lg_sel),
    .y_o  (lg_y)
  );

  // operand steering for the shared adder
  always_comb begin
    as_b   = opnd_i;
    as_sub = 1'b0;
    lg_sel = LG_AND;
    unique case (op)
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_INC:         as_b   = ONE;
      OP_DEC: begin
        as_b   = ONE;
        as_sub = 1'b1;
      end
      OP_OR:  lg_sel = LG_OR;
      OP_XOR: lg_sel = LG_XOR;
      default: ;
    endcase
  end

  // result, write enable, carry flags and per-op flag mask
  always_comb begin
    res  = acc_i;
    we   = 1'b0;
    cy_n = 1'b0;
    ac_n = 1'b0;
    mask = '0;
    unique case (op)
      OP_ADD, OP_SUB, OP_CMP: begin
        res  = as_sum;
        we   = (op != OP_CMP);
        cy_n = as_cout;
        ac_n = as_half;
        mask = '1;
      end
      OP_INC, OP_DEC: begin
        res     = as_sum;
        we      = 1'b1;
        ac_n    = as_half;
        mask    = '1;
        mask.cy = 1'b0;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res  = lg_y;
        we   = 1'b1;
        ac_n = (op == OP_AND);
        mask = '1;
      end
      OP_RLC: begin
        res     = {acc_i[MSB-1:0], acc_i[MSB]};
        we      = 1'b1;
        cy_n    = acc_i[MSB];
        mask.cy = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    nxt.s  = res[MSB];
    nxt.z  = (res == '0);
    nxt.ac = ac_n;
    nxt.p  = ~^res;
    nxt.cy = cy_n;
  end

  acc_alu_flag_reg u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (flag_en_i),
    .mask_i(mask),
    .next_i(nxt),
    .q_o   (cur)
  );

  assign result_o = res;
  assign acc_we_o = we;
  assign flags_o  = cur;
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] acc_i,
  input logic              flag_en_i,
  input logic [DATA_W-1:0] result_o,
  input logic              acc_we_o,
  input logic [FLAG_W-1:0] flags_o
);
  localparam int MSB = DATA_W - 1;

  p_cmp_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |-> !acc_we_o);

  p_incdec_keep_cy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && (op_i == OP_INC || op_i == OP_DEC)) |=> flags_o[0] == $past(flags_o[0]));

  p_and_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && op_i == OP_AND) |=> (flags_o[2] && !flags_o[0]));

  p_orxor_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && (op_i == OP_OR || op_i == OP_XOR)) |=> (!flags_o[2] && !flags_o[0]));

  p_rlc_only_cy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && op_i == OP_RLC) |=>
      (flags_o[4:1] == $past(flags_o[4:1]) && flags_o[0] == $past(acc_i[MSB])));

  p_add_zero_parity_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && op_i == OP_ADD) |=>
      (flags_o[3] == ($past(result_o) == '0) && flags_o[1] == ~^$past(result_o)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_en_i |=> $stable(flags_o));

  p_unused_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_RLC) |-> (!acc_we_o && result_o == acc_i));

  p_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i <= OP_RLC && op_i != OP_CMP) |-> acc_we_o);
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .acc_i    (acc_i),
  .flag_en_i(flag_en_i),
  .result_o (result_o),
  .acc_we_o (acc_we_o),
  .flags_o  (flags_o)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0;
  logic [7:0] opnd_i = '0;
  logic       flag_en_i = 1'b0;
  logic [7:0] result_o;
  logic       acc_we_o;
  logic [4:0] flags_o;

  int checks = 0;
  int fails  = 0;
  logic [4:0] mdl_f = '0;

  localparam logic [7:0] BV [16] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFE, 8'hFF,
                                     8'h5A, 8'hA5, 8'h33, 8'hC3, 8'h08, 8'hF0, 8'h99, 8'h66};

  always #10 clk_i = ~clk_i;  // 50 MHz

  acc_alu u_acc_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .flag_en_i(flag_en_i), .result_o(result_o), .acc_we_o(acc_we_o), .flags_o(flags_o)
  );

  function automatic string tag_of(input int op);
    case (op)
      0:       return "R1";
      1:       return "R2";
      2, 3:    return "R4";
      4:       return "R5";
      5, 6:    return "R6";
      7:       return "R3";
      8:       return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic ref_model(input int op, input logic [7:0] a, input logic [7:0] b,
                           input logic [4:0] f, output logic [7:0] r, output logic we,
                           output logic [4:0] nf);
    int s;
    logic cy, ac;
    logic [4:0] mask, full;
    r = a; we = 1'b0; mask = 5'h00; cy = 1'b0; ac = 1'b0;
    case (op)
      0: begin s = a + b; r = s[7:0]; cy = s > 255; ac = (a % 16 + b % 16) > 15; mask = 5'h1F; we = 1'b1; end
      1, 7: begin r = a - b; cy = b > a; ac = (b % 16) > (a % 16); mask = 5'h1F; we = (op == 1); end
      2: begin r = a + 8'd1; ac = (a % 16) == 15; mask = 5'h1E; we = 1'b1; end
      3: begin r = a - 8'd1; ac = (a % 16) == 0; mask = 5'h1E; we = 1'b1; end
      4: begin r = a & b; ac = 1'b1; mask = 5'h1F; we = 1'b1; end
      5: begin r = a | b; mask = 5'h1F; we = 1'b1; end
      6: begin r = a ^ b; mask = 5'h1F; we = 1'b1; end
      8: begin r = {a[6:0], a[7]}; cy = a[7]; mask = 5'h01; we = 1'b1; end
      default: ;
    endcase
    full = {r[7], r == 8'h00, ac, ($countones(r) % 2) == 0, cy};
    nf = (f & ~mask) | (full & mask);
  endtask

  task automatic chk(input string tag, input string what, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input int op, input logic [7:0] a, input logic [7:0] b, input logic en);
    logic [7:0] r;
    logic we;
    logic [4:0] nf;
    @(negedge clk_i);
    op_i = 4'(op); acc_i = a; opnd_i = b; flag_en_i = en;
    ref_model(op, a, b, mdl_f, r, we, nf);
    #2;
    chk(tag_of(op), "result/we (R11)", {acc_we_o, result_o}, {we, r});
    @(posedge clk_i);
    #2;
    if (en) mdl_f = nf;
    chk(en ? tag_of(op) : "R9", "flags (R8)", {4'b0, flags_o}, {4'b0, mdl_f});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    chk("R9", "reset flags", {4'b0, flags_o}, 9'h000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // documented examples
    apply(0, 8'h7F, 8'h01, 1'b1);
    chk("R1", "7F+01 flags", {4'b0, flags_o}, {4'b0, 5'b10100});
    apply(4, 8'h7F, 8'h0F, 1'b1);
    chk("R5", "7F&0F flags", {4'b0, flags_o}, {4'b0, 5'b00110});
    apply(8, 8'h7F, 8'h00, 1'b1);
    chk("R7", "RLC 7F result", {1'b0, result_o}, 9'h0FE);
    apply(7, 8'h10, 8'h20, 1'b1);
    chk("R3", "CMP borrow", {8'b0, flags_o[0]}, 9'h001);

    // near-exhaustive sweep: all accumulators x 16 operands x all ops
    for (int a = 0; a < 256; a++)
      for (int bi = 0; bi < 16; bi++)
        for (int op = 0; op < 9; op++)
          apply(op, 8'(a), BV[bi], ((a + bi + op) % 7) != 0);

    // unused codes must not touch flags even when enabled
    apply(0, 8'hFF, 8'h01, 1'b1);
    for (int op = 9; op < 16; op++)
      for (int a = 0; a < 256; a += 37)
        apply(op, 8'(a), 8'h55, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule